// File: doc/BRIEF.md
# Audio Port Control and Status Register Block

This block is the software-visible register interface of a serial audio port. It keeps one control word and one status word. Each word can be reached at three write addresses: a plain address that loads the word, a set address that ORs the written data into it, and a clear address that removes every bit written as one. Software can therefore flip a single bit without first reading the word back.

The control word carries a soft reset bit, a clock gate bit, a run bit, a transfer direction bit, a FIFO error interrupt enable and an eight-bit format field. The status word carries sticky FIFO underflow and overflow flags, set by pulses from the FIFO side, plus a busy bit that mirrors an active transfer. The block raises an interrupt when the error interrupt is enabled and either error flag is set. The FIFO storage and the bus fabric sit outside the block.

Top module: `aport_csr`

## Requirements
- R1: After reset the control word reads 0xC000_0000 (soft reset bit 31 and clock gate bit 30 set, all else zero), the status word reads zero and `irq` is low.
- R2: Address map, byte offsets: control plain 0x00, control set 0x04, control clear 0x08, status plain 0x10, status set 0x14, status clear 0x18. A plain write to 0x00 loads the control word; only the implemented bits (31, 30, 15:8, 2, 1, 0; mask 0xC000_FF07) are stored, the rest read zero. Reads of 0x00, 0x04 and 0x08 all return the control word, and `ctrl_word` equals it.
- R3: A write to the control set address ORs the data into the control word; a write to the control clear address clears the bits written as one and leaves the others.
- R4: With soft reset and clock gate both clear, a cycle with `tx_need` and `tx_empty` both high sets the underflow flag (status bit 16), and a cycle with `rx_push` and `rx_full` both high sets the overflow flag (status bit 17). The flag is visible one cycle after the event.
- R5: The error flags are sticky: a plain write to 0x10 leaves them unchanged, a write to 0x14 sets the flags written as one, and only a write to 0x18 with the bit as one clears a flag.
- R6: When a FIFO event and a clear of the same flag fall in the same cycle, the flag stays set.
- R7: While control bit 31 (soft reset) is set, both error flags are held at zero from the following cycle, FIFO events and status set writes are ignored, and the status busy bit reads zero.
- R8: While control bit 30 (clock gate) is set and soft reset is clear, FIFO events do not set the flags, while status set and clear writes still act.
- R9: `irq` is high exactly when control bit 2 (error interrupt enable) is set and at least one error flag is set.
- R10: Status bit 0 reports `xfer_busy` (outside soft reset); while it is high, control writes through any alias leave the format field (bits 15:8) unchanged and still update the other bits.
- R11: Writes to any undecoded address (offsets 0x0C, 0x1C, any offset not a multiple of four, any offset at or above 0x20) change nothing, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| tx_need | input | 1 | Transmit side requests a word this cycle |
| tx_empty | input | 1 | FIFO has no word for transmit |
| rx_push | input | 1 | Receive side delivers a word this cycle |
| rx_full | input | 1 | FIFO has no room for receive |
| xfer_busy | input | 1 | A transfer is in progress |
| ctrl_word | output | DW | Current control word |
| irq | output | 1 | FIFO error interrupt |

## Verification
The hardest situation to reach is the collision of a FIFO event with a clear of the same flag in one cycle, and the interplay of the two gating bits with events that arrive while they are set. The stimulus drives the event pulse and the clear-alias write on the same falling edge so both land on one rising edge, then walks the block through soft reset, clock gate and normal states with the same event pulses. The interrupt is swept over every combination of enable and the two flags, built only through the set and clear aliases.

// File: rtl/aport_csr.sv
module aport_csr #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tx_need,
  input  logic          tx_empty,
  input  logic          rx_push,
  input  logic          rx_full,
  input  logic          xfer_busy,
  output logic [DW-1:0] ctrl_word,
  output logic          irq
);
  localparam int B_SRST = 31;
  localparam int B_GATE = 30;
  localparam int B_IEN  = 2;
  localparam int B_UF   = 16;
  localparam int B_OF   = 17;
  localparam logic [DW-1:0] CTRL_RST  = DW'(32'hC000_0000);
  localparam logic [DW-1:0] CTRL_IMPL = DW'(32'hC000_FF07);
  localparam logic [DW-1:0] FMT_MASK  = DW'(32'h0000_FF00);

  logic [DW-1:0] ctrl_q, ctrl_d, ctrl_w;
  logic          uf_q, of_q;

  logic       hi_zero, valid, sel_ctrl, sel_stat;
  logic [1:0] alias_sel;

  assign hi_zero   = (bus_addr >> 5) == '0;
  assign alias_sel = bus_addr[3:2];
  assign valid     = hi_zero && bus_addr[1:0] == 2'b00 && alias_sel != 2'b11;
  assign sel_ctrl  = valid && !bus_addr[4];
  assign sel_stat  = valid &&  bus_addr[4];

  logic srst, gate, busy_eff;
  assign srst     = ctrl_q[B_SRST];
  assign gate     = ctrl_q[B_GATE];
  assign busy_eff = xfer_busy && !srst;

  always_comb begin
    ctrl_w = ctrl_q;
    if (bus_wr && sel_ctrl) begin
      case (alias_sel)
        2'b00:   ctrl_w = bus_wdata;
        2'b01:   ctrl_w = ctrl_q | bus_wdata;
        default: ctrl_w = ctrl_q & ~bus_wdata;
      endcase
    end
    ctrl_w = ctrl_w & CTRL_IMPL;
    ctrl_d = busy_eff ? ((ctrl_w & ~FMT_MASK) | (ctrl_q & FMT_MASK)) : ctrl_w;
  end

  logic st_set, st_clr, uf_ev, of_ev, uf_d, of_d;
  assign st_set = bus_wr && sel_stat && alias_sel == 2'b01;
  assign st_clr = bus_wr && sel_stat && alias_sel == 2'b10;
  assign uf_ev  = !srst && !gate && tx_need && tx_empty;
  assign of_ev  = !srst && !gate && rx_push && rx_full;

  assign uf_d = srst ? 1'b0
              : (uf_q && !(st_clr && bus_wdata[B_UF])) || (st_set && bus_wdata[B_UF]) || uf_ev;
  assign of_d = srst ? 1'b0
              : (of_q && !(st_clr && bus_wdata[B_OF])) || (st_set && bus_wdata[B_OF]) || of_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      uf_q   <= 1'b0;
      of_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      uf_q   <= uf_d;
      of_q   <= of_d;
    end
  end

  logic [DW-1:0] stat_word;
  always_comb begin
    stat_word        = '0;
    stat_word[0]     = busy_eff;
    stat_word[B_UF]  = uf_q;
    stat_word[B_OF]  = of_q;
  end

  assign bus_rdata = sel_ctrl ? ctrl_q : sel_stat ? stat_word : '0;
  assign ctrl_word = ctrl_q;
  assign irq       = ctrl_q[B_IEN] && (uf_q || of_q);
endmodule

// File: rtl/aport_csr_chk.sv
module aport_csr_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          tx_need,
  input logic          tx_empty,
  input logic          xfer_busy,
  input logic [DW-1:0] ctrl_q,
  input logic          uf_q,
  input logic          of_q,
  input logic          irq
);
  logic undecoded, clr_uf;
  assign undecoded = (bus_addr >> 5) != '0 || bus_addr[1:0] != 2'b00 || bus_addr[3:2] == 2'b11;
  assign clr_uf    = bus_wr && bus_addr == AW'(8'h18) && bus_wdata[16];

  p_underflow_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_need && tx_empty && !ctrl_q[31] && !ctrl_q[30] |=> uf_q);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q && !clr_uf && !ctrl_q[31] |=> uf_q);

  p_reset_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[31] |=> !uf_q && !of_q);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (uf_q || of_q));

  p_fmt_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy && !ctrl_q[31] |=> $stable(ctrl_q[15:8]));

  p_undecoded_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && undecoded |=> $stable(ctrl_q));
endmodule

bind aport_csr aport_csr_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tx_need(tx_need), .tx_empty(tx_empty),
  .xfer_busy(xfer_busy), .ctrl_q(ctrl_q), .uf_q(uf_q), .of_q(of_q), .irq(irq)
);

// File: tb/tb_aport_csr.sv
module tb_aport_csr;
  localparam logic [31:0] IMPL = 32'hC000_FF07;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, ctrl_word;
  logic tx_need = 0, tx_empty = 0, rx_push = 0, rx_full = 0, xfer_busy = 0;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] cm;

  always #5 clk = ~clk;

  aport_csr dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_need(tx_need), .tx_empty(tx_empty),
    .rx_push(rx_push), .rx_full(rx_full), .xfer_busy(xfer_busy),
    .ctrl_word(ctrl_word), .irq(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = 0;
  endtask

  task automatic ev(input logic tn, input logic te, input logic rp, input logic rf);
    @(negedge clk); tx_need = tn; tx_empty = te; rx_push = rp; rx_full = rf;
    @(negedge clk); tx_need = 0; tx_empty = 0; rx_push = 0; rx_full = 0;
  endtask

  function automatic logic [31:0] st(input logic of, input logic uf, input logic b);
    return (32'(of) << 17) | (32'(uf) << 16) | 32'(b);
  endfunction

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h00, r); chk("R1 ctrl reset", r, 32'hC000_0000);
    rd(8'h10, r); chk("R1 status reset", r, 0);
    chk("R1 irq reset", 32'(irq), 0);

    wr(8'h08, 32'hC000_0000); cm = 0;
    rd(8'h00, r); chk("R3 clear alias", r, cm);

    for (int i = 0; i < 16; i++) begin
      logic [31:0] p;
      p = {i[3:0], i[3:0] ^ 4'h5, 16'hA5A5, ~i[3:0], 4'h3} | 32'h0;
      p[31:30] = 2'b00;
      wr(8'h00, p); cm = p & IMPL;
      rd(8'h00, r); chk("R2 plain", r, cm);
      rd(8'h04, r); chk("R2 set alias read", r, cm);
      rd(8'h08, r); chk("R2 clr alias read", r, cm);
      chk("R2 ctrl_word", ctrl_word, cm);
    end
    wr(8'h00, 0); cm = 0;

    for (int i = 0; i < 16; i++) begin
      logic [31:0] s, c;
      s = 32'h1 << (i % 3) | (32'h100 << (i % 8)) | (i[0] ? 32'h4000_0000 : 0);
      c = 32'h1 << ((i + 1) % 3) | (32'h100 << ((i * 3) % 8));
      wr(8'h04, s); cm = (cm | s) & IMPL;
      rd(8'h00, r); chk("R3 set", r, cm);
      wr(8'h08, c); cm = cm & ~c;
      rd(8'h00, r); chk("R3 clear", r, cm);
    end
    wr(8'h00, 0); cm = 0;

    ev(1, 0, 0, 0); ev(0, 1, 0, 0); ev(0, 0, 1, 0); ev(0, 0, 0, 1);
    rd(8'h10, r); chk("R4 no event", r, 0);
    ev(1, 1, 0, 0);
    rd(8'h10, r); chk("R4 underflow", r, st(0, 1, 0));
    ev(0, 0, 1, 1);
    rd(8'h10, r); chk("R4 overflow", r, st(1, 1, 0));

    wr(8'h10, 0);
    rd(8'h10, r); chk("R5 plain ignored", r, st(1, 1, 0));
    wr(8'h18, 32'h0001_0000);
    rd(8'h10, r); chk("R5 clear uf", r, st(1, 0, 0));
    wr(8'h18, 32'h0002_0000);
    rd(8'h10, r); chk("R5 clear of", r, 0);
    wr(8'h14, 32'h0001_0000);
    rd(8'h10, r); chk("R5 set alias", r, st(0, 1, 0));

    @(negedge clk); bus_wr = 1; bus_addr = 8'h18; bus_wdata = 32'h0001_0000;
    tx_need = 1; tx_empty = 1;
    @(negedge clk); bus_wr = 0; bus_addr = 0; bus_wdata = 0; tx_need = 0; tx_empty = 0;
    rd(8'h10, r); chk("R6 event beats clear", r, st(0, 1, 0));
    wr(8'h18, 32'h0003_0000);

    for (int i = 0; i < 8; i++) begin
      wr(8'h00, i[2] ? 32'h4 : 0);
      wr(8'h18, 32'h0003_0000);
      wr(8'h14, (32'(i[0]) << 16) | (32'(i[1]) << 17));
      #1; chk("R9 irq sweep", 32'(irq), 32'(i[2] && (i[0] || i[1])));
    end
    wr(8'h18, 32'h0003_0000); wr(8'h00, 0); cm = 0;

    wr(8'h14, 32'h0003_0000);
    xfer_busy = 1;
    wr(8'h04, 32'h8000_0000);
    @(negedge clk);
    rd(8'h10, r); chk("R7 flags held, busy masked", r, 0);
    ev(1, 1, 1, 1);
    wr(8'h14, 32'h0003_0000);
    rd(8'h10, r); chk("R7 events and set ignored", r, 0);
    xfer_busy = 0;
    wr(8'h08, 32'h8000_0000);

    wr(8'h04, 32'h4000_0000);
    ev(1, 1, 1, 1);
    rd(8'h10, r); chk("R8 gate blocks events", r, 0);
    wr(8'h14, 32'h0002_0000);
    rd(8'h10, r); chk("R8 set under gate", r, st(1, 0, 0));
    wr(8'h18, 32'h0002_0000);
    rd(8'h10, r); chk("R8 clear under gate", r, 0);
    wr(8'h00, 32'h0000_3C00); cm = 32'h0000_3C00;

    xfer_busy = 1; #1;
    rd(8'h10, r); chk("R10 busy bit", r, st(0, 0, 1));
    wr(8'h00, 32'h0000_AB05); cm = 32'h0000_3C05;
    rd(8'h00, r); chk("R10 fmt locked plain", r, cm);
    wr(8'h08, 32'h0000_FF01); cm = 32'h0000_3C04;
    rd(8'h00, r); chk("R10 fmt locked clear", r, cm);
    xfer_busy = 0;
    wr(8'h00, 32'h0000_AB05); cm = 32'h0000_AB05;
    rd(8'h00, r); chk("R10 fmt writable idle", r, cm);

    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h1C, 32'h0003_0000);
    wr(8'h20, 0); wr(8'h02, 0); wr(8'h86, 0);
    rd(8'h00, r); chk("R11 ctrl untouched", r, cm);
    rd(8'h10, r); chk("R11 status untouched", r, 0);
    rd(8'h0C, r); chk("R11 read zero", r, 0);
    rd(8'h24, r); chk("R11 read zero high", r, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule